// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segmented logical address into a 24-bit physical address. The logical address has two parts: a 7-bit segment number and a 16-bit offset. Three descriptor tables are kept, one for code, one for data and one for stack references. Each table holds 64 descriptors. The table used for an access comes from the encoded bus status that arrives with it. Each descriptor holds a base in 256-byte units, a length limit in 256-byte blocks and a system-only attribute. The normal/system mode input is checked against that attribute.

A logical address strobe starts a translation. One clock later the block presents a registered physical address together with either a valid strobe or a violation flag. A violation is raised when the offset runs past the segment length, when a normal-mode access reaches a system-only segment, or when the segment number is outside the table. Each table has its own address/data/write-enable port for loading descriptors. Bit 1 of an 8-bit configuration input switches translation on. While that bit is clear, the logical address passes through unchanged and no violation is ever raised.

Top module: `seg_xlat_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `pa_vld` and `pa_viol` are 0 and `pa` is 0. All descriptors reset to zero: base 0, limit 0, not system-only.
- R2: When `cfg_reg[1]` is 0, an accepted access gives `pa = {1'b0, la_seg, la_off}`, `pa_vld = 1` and `pa_viol = 0`. This holds whatever the descriptors, the mode and the other configuration bits are.
- R3: When `cfg_reg[1]` is 1 and no violation occurs, `pa = (base << 8) + la_off`, truncated to 24 bits. The base comes from the selected descriptor.
- R4: The status value selects the table. Status 4'hC and 4'hD (instruction fetch) use the code table, written through port slice 0. Status 4'h8 uses the data table, port slice 1. Status 4'h9 uses the stack table, port slice 2.
- R5: An access is accepted only when `la_stb` is 1 and the status is one of the four memory codes of R4. In the cycle after any other cycle, `pa_vld` and `pa_viol` are 0 and `pa` keeps its previous value.
- R6: When translation is on, the access is a violation if `la_off[15:8]` is greater than the descriptor limit. An upper offset byte equal to the limit is allowed.
- R7: When translation is on and `la_sys` is 0 (normal mode), an access to a descriptor with its system-only bit set is a violation. With `la_sys` = 1 the bit has no effect.
- R8: When translation is on, a segment number of 64 or higher (`la_seg[6]` = 1) is a violation.
- R9: Results appear exactly one clock after the accepted strobe. On a violation, `pa_viol` = 1 and `pa_vld` = 0.
- R10: The descriptor word on `dw_data` packs the base in bits [15:0], the limit in bits [23:16] and the system-only bit in bit 24. Each 25-bit slice k of `dw_data` goes with the 6-bit slice k of `dw_idx`. A write is stored at the clock edge. A lookup of the same entry in the same cycle uses the old descriptor, and the next cycle uses the new one.
- R11: `pa_vld` and `pa_viol` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_reg | input | 8 | Configuration register; bit 1 enables translation |
| la_stb | input | 1 | Logical address strobe |
| la_seg | input | 7 | Segment number |
| la_off | input | 16 | Offset within segment |
| la_status | input | 4 | Encoded bus status of the access |
| la_sys | input | 1 | 1 = system mode, 0 = normal mode |
| dw_en | input | 3 | Descriptor write enable, one bit per table |
| dw_idx | input | 18 | Descriptor index, 6 bits per table |
| dw_data | input | 75 | Descriptor word, 25 bits per table |
| pa | output | 24 | Registered physical address |
| pa_vld | output | 1 | Physical address valid strobe |
| pa_viol | output | 1 | Access violation flag |

## Verification
A descriptor write and a lookup of the same entry can land in the same clock, and the lookup must then use the old descriptor. The bench provokes this on purpose in a directed step and also makes it frequent in the random phase, where the write index is often forced to equal the access segment. The bench reference model computes each expectation from its descriptor copy before it applies that cycle's writes, so a design that forwards the new word is caught. Limit, mode and range violations can also arise together in one access. They are judged together as a single flag, which must be set whenever any one of the three conditions holds.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
   localparam int NTAB = 3;

   typedef enum logic [1:0] {
      TAB_CODE  = 2'd0,
      TAB_DATA  = 2'd1,
      TAB_STACK = 2'd2,
      TAB_NONE  = 2'd3
   } tab_e;

   // Map the encoded bus status to a table; TAB_NONE means no memory access
   function automatic tab_e status_to_tab(input logic [3:0] st);
      tab_e t;
      case (st)
         4'hC, 4'hD: t = TAB_CODE;
         4'h8:       t = TAB_DATA;
         4'h9:       t = TAB_STACK;
         default:    t = TAB_NONE;
      endcase
      return t;
   endfunction
endpackage

// File: rtl/seg_xlat_sel.sv
module seg_xlat_sel
   import seg_xlat_pkg::*;
(
   input  logic [3:0] status,
   output tab_e       sel,
   output logic       is_mem
);
   always_comb begin
      sel    = status_to_tab(status);
      is_mem = (sel != TAB_NONE);
   end
endmodule

// File: rtl/seg_xlat_table.sv
module seg_xlat_table #(
   parameter int NSEG   = 64,
   parameter int DESC_W = 25,
   localparam int IDX_W = $clog2(NSEG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DESC_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DESC_W-1:0] rdata
);
   logic [DESC_W-1:0] mem [NSEG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NSEG; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   // Read is combinational from stored state: a same-cycle write is not forwarded
   assign rdata = mem[ridx];
endmodule

// File: rtl/seg_xlat_calc.sv
module seg_xlat_calc #(
   parameter int SEG_W       = 7,
   parameter int OFF_W       = 16,
   parameter int PA_W        = 24,
   parameter int IDX_W       = 6,
   parameter int BASE_W      = 16,
   parameter int LIM_W       = 8,
   parameter int BLK_SH      = 8,
   parameter bit LIMIT_CHECK = 1'b1,
   localparam int DESC_W     = 1 + LIM_W + BASE_W,
   localparam int SUM_W      = BASE_W + BLK_SH
) (
   input  logic              enable,
   input  logic              sys_mode,
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   input  logic [DESC_W-1:0] desc,
   output logic [PA_W-1:0]   pa_n,
   output logic              viol_n
);
   logic [BASE_W-1:0] base;
   logic [LIM_W-1:0]  limit;
   logic              sys_only;
   logic [SUM_W:0]    sum;
   logic              over_len;
   logic              seg_out;
   logic              mode_bad;

   assign base     = desc[BASE_W-1:0];
   assign limit    = desc[BASE_W +: LIM_W];
   assign sys_only = desc[DESC_W-1];

   assign sum = {1'b0, base, {BLK_SH{1'b0}}} + (SUM_W+1)'(off);

   generate
      if (LIMIT_CHECK) begin : g_lim
         assign over_len = (off[OFF_W-1:BLK_SH] > limit);
      end else begin : g_nolim
         assign over_len = 1'b0;
      end
   endgenerate

   assign seg_out  = |seg[SEG_W-1:IDX_W];
   assign mode_bad = sys_only & ~sys_mode;

   always_comb begin
      if (enable) begin
         pa_n   = sum[PA_W-1:0];
         viol_n = over_len | seg_out | mode_bad;
      end else begin
         pa_n   = PA_W'({seg, off});
         viol_n = 1'b0;
      end
   end
endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
   import seg_xlat_pkg::*;
#(
   parameter int SEG_W       = 7,
   parameter int OFF_W       = 16,
   parameter int PA_W        = 24,
   parameter int NSEG        = 64,
   parameter int BASE_W      = 16,
   parameter int LIM_W       = 8,
   parameter int BLK_SH      = 8,
   parameter int CFG_W       = 8,
   parameter int EN_BIT      = 1,
   parameter bit LIMIT_CHECK = 1'b1
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [CFG_W-1:0]                         cfg_reg,
   input  logic                                     la_stb,
   input  logic [SEG_W-1:0]                         la_seg,
   input  logic [OFF_W-1:0]                         la_off,
   input  logic [3:0]                               la_status,
   input  logic                                     la_sys,
   input  logic [NTAB-1:0]                          dw_en,
   input  logic [NTAB*$clog2(NSEG)-1:0]             dw_idx,
   input  logic [NTAB*(1+LIM_W+BASE_W)-1:0]         dw_data,
   output logic [PA_W-1:0]                          pa,
   output logic                                     pa_vld,
   output logic                                     pa_viol
);
   localparam int IDX_W  = $clog2(NSEG);
   localparam int DESC_W = 1 + LIM_W + BASE_W;

   generate
      if (IDX_W >= SEG_W) begin : g_bad_seg
         $error("segment field must be wider than the table index");
      end
      if (PA_W < SEG_W + OFF_W) begin : g_bad_pa
         $error("physical width too small for pass-through");
      end
      if (OFF_W - BLK_SH != LIM_W) begin : g_bad_lim
         $error("limit width must match the upper offset field");
      end
      if (BASE_W + BLK_SH < PA_W) begin : g_bad_base
         $error("shifted base must cover the physical width");
      end
      if (EN_BIT >= CFG_W) begin : g_bad_en
         $error("enable bit outside configuration register");
      end
   endgenerate

   tab_e              sel;
   logic              is_mem;
   logic [DESC_W-1:0] rd [NTAB];
   logic [DESC_W-1:0] desc;
   logic [PA_W-1:0]   pa_n;
   logic              viol_n;
   logic              accept;

   seg_xlat_sel u_sel (
      .status (la_status),
      .sel    (sel),
      .is_mem (is_mem)
   );

   generate
      for (genvar t = 0; t < NTAB; t++) begin : g_tab
         seg_xlat_table #(.NSEG(NSEG), .DESC_W(DESC_W)) u_tab (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (dw_en[t]),
            .widx  (dw_idx[t*IDX_W +: IDX_W]),
            .wdata (dw_data[t*DESC_W +: DESC_W]),
            .ridx  (la_seg[IDX_W-1:0]),
            .rdata (rd[t])
         );
      end
   endgenerate

   always_comb begin
      case (sel)
         TAB_CODE:  desc = rd[0];
         TAB_DATA:  desc = rd[1];
         TAB_STACK: desc = rd[2];
         default:   desc = '0;
      endcase
   end

   seg_xlat_calc #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .IDX_W(IDX_W),
      .BASE_W(BASE_W), .LIM_W(LIM_W), .BLK_SH(BLK_SH),
      .LIMIT_CHECK(LIMIT_CHECK)
   ) u_calc (
      .enable   (cfg_reg[EN_BIT]),
      .sys_mode (la_sys),
      .seg      (la_seg),
      .off      (la_off),
      .desc     (desc),
      .pa_n     (pa_n),
      .viol_n   (viol_n)
   );

   assign accept = la_stb & is_mem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa      <= '0;
         pa_vld  <= 1'b0;
         pa_viol <= 1'b0;
      end else if (accept) begin
         pa      <= pa_n;
         pa_vld  <= ~viol_n;
         pa_viol <= viol_n;
      end else begin
         pa_vld  <= 1'b0;
         pa_viol <= 1'b0;
      end
   end
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk
   import seg_xlat_pkg::*;
#(
   parameter int SEG_W  = 7,
   parameter int OFF_W  = 16,
   parameter int PA_W   = 24,
   parameter int IDX_W  = 6,
   parameter int BLK_SH = 8,
   parameter int CFG_W  = 8,
   parameter int EN_BIT = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] cfg_reg,
   input logic             la_stb,
   input logic [SEG_W-1:0] la_seg,
   input logic [OFF_W-1:0] la_off,
   input logic [3:0]       la_status,
   input logic [PA_W-1:0]  pa,
   input logic             pa_vld,
   input logic             pa_viol
);
   logic mem_acc;
   assign mem_acc = la_stb && (status_to_tab(la_status) != TAB_NONE);

   AST_VLD_VIOL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pa_vld && pa_viol)); // R11

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_acc |=> (!pa_vld && !pa_viol)); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_acc |=> $stable(pa)); // R5

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_acc && !cfg_reg[EN_BIT]) |=>
         (pa_vld && pa == $past(PA_W'({la_seg, la_off})))); // R2

   AST_LOW_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      mem_acc |=> (pa[BLK_SH-1:0] == $past(la_off[BLK_SH-1:0]))); // R3

   AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_acc && cfg_reg[EN_BIT] && (|la_seg[SEG_W-1:IDX_W])) |=> pa_viol); // R8
endmodule

bind seg_xlat_top seg_xlat_chk #(
   .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .IDX_W($clog2(NSEG)),
   .BLK_SH(BLK_SH), .CFG_W(CFG_W), .EN_BIT(EN_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_reg(cfg_reg), .la_stb(la_stb),
   .la_seg(la_seg), .la_off(la_off), .la_status(la_status),
   .pa(pa), .pa_vld(pa_vld), .pa_viol(pa_viol)
);

// File: tb/sim_seg_xlat_top.sv
module sim_seg_xlat_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_reg = 8'h00;
   logic        la_stb = 1'b0;
   logic [6:0]  la_seg = '0;
   logic [15:0] la_off = '0;
   logic [3:0]  la_status = '0;
   logic        la_sys = 1'b0;
   logic [2:0]  dw_en = '0;
   logic [17:0] dw_idx = '0;
   logic [74:0] dw_data = '0;
   logic [23:0] pa;
   logic        pa_vld;
   logic        pa_viol;

   int checks = 0;
   int errors = 0;

   logic [24:0] mdl [3][64];
   logic [23:0] e_pa = '0;
   logic        e_vld = 1'b0;
   logic        e_viol = 1'b0;

   always #5 clk = ~clk;

   seg_xlat_top u0 (
      .clk(clk), .rst_n(rst_n), .cfg_reg(cfg_reg), .la_stb(la_stb),
      .la_seg(la_seg), .la_off(la_off), .la_status(la_status), .la_sys(la_sys),
      .dw_en(dw_en), .dw_idx(dw_idx), .dw_data(dw_data),
      .pa(pa), .pa_vld(pa_vld), .pa_viol(pa_viol)
   );

   function automatic int tab_of(input logic [3:0] st);
      if (st == 4'hC || st == 4'hD) return 0;
      if (st == 4'h8) return 1;
      if (st == 4'h9) return 2;
      return -1;
   endfunction

   function automatic logic [24:0] mk_desc(input logic sys, input logic [7:0] lim,
                                           input logic [15:0] base);
      return {sys, lim, base};
   endfunction

   task automatic check(input string tag);
      checks++;
      if (pa !== e_pa || pa_vld !== e_vld || pa_viol !== e_viol) begin
         errors++;
         $display("FAIL %s: got pa=%h vld=%b viol=%b expected pa=%h vld=%b viol=%b",
                  tag, pa, pa_vld, pa_viol, e_pa, e_vld, e_viol);
      end
   endtask

   // Compute expectation from model (before this cycle's writes), then update model
   task automatic model_step;
      int t;
      logic [24:0] d;
      logic [24:0] s;
      t = tab_of(la_status);
      if (la_stb && t >= 0) begin
         if (!cfg_reg[1]) begin
            e_pa = {1'b0, la_seg, la_off}; e_vld = 1'b1; e_viol = 1'b0;
         end else begin
            d = mdl[t][la_seg[5:0]];
            s = {1'b0, d[15:0], 8'h00} + {9'h0, la_off};
            e_pa = s[23:0];
            e_viol = la_seg[6] || (la_off[15:8] > d[23:16]) || (!la_sys && d[24]);
            e_vld = !e_viol;
         end
      end else begin
         e_vld = 1'b0; e_viol = 1'b0;
      end
      for (int k = 0; k < 3; k++)
         if (dw_en[k]) mdl[k][dw_idx[k*6 +: 6]] = dw_data[k*25 +: 25];
   endtask

   // Called right after a falling edge with inputs driven; checks at the next falling edge
   task automatic step(input string tag);
      model_step();
      @(negedge clk);
      check(tag);
      dw_en = '0;
   endtask

   task automatic wr(input int t, input int idx, input logic [24:0] d);
      dw_en = '0; dw_en[t] = 1'b1;
      dw_idx[t*6 +: 6] = 6'(idx);
      dw_data[t*25 +: 25] = d;
   endtask

   task automatic acc(input logic [6:0] seg, input logic [15:0] off,
                      input logic [3:0] st, input logic sys);
      la_stb = 1'b1; la_seg = seg; la_off = off; la_status = st; la_sys = sys;
   endtask

   initial begin
      #2000000;
      errors++; checks++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int seed;
      logic [1:0] bucket;
      int sc;
      seed = $urandom(32'h5EC7);
      for (int a = 0; a < 3; a++) for (int b = 0; b < 64; b++) mdl[a][b] = '0;

      @(negedge clk); @(negedge clk);
      check("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset");

      // R2: pass-through with other config bits set and odd inputs
      cfg_reg = 8'hFD;
      acc(7'h7F, 16'hFFFF, 4'h8, 1'b0); step("R2 passthru");
      acc(7'h15, 16'h1234, 4'hC, 1'b1); step("R2 passthru code");

      // R4/R3: same segment, different base per table
      cfg_reg = 8'h02;
      la_stb = 1'b0;
      wr(0, 5, mk_desc(1'b0, 8'hFF, 16'h1234)); step("R5 idle");
      wr(1, 5, mk_desc(1'b0, 8'hFF, 16'h2000)); step("R5 idle");
      wr(2, 5, mk_desc(1'b0, 8'hFF, 16'hFFFF)); step("R5 idle");
      acc(7'd5, 16'h00AB, 4'hC, 1'b0); step("R4 code table");
      acc(7'd5, 16'h00AB, 4'hD, 1'b0); step("R4 code table next");
      acc(7'd5, 16'h00AB, 4'h8, 1'b0); step("R4 data table");
      acc(7'd5, 16'h0200, 4'h9, 1'b0); step("R3 stack wrap");
      la_stb = 1'b0; step("R9 strobe gone");

      // R6: limit boundary
      wr(1, 6, mk_desc(1'b0, 8'h10, 16'h0040)); la_stb = 1'b0; step("R5 idle");
      acc(7'd6, 16'h10FF, 4'h8, 1'b0); step("R6 at limit");
      acc(7'd6, 16'h1100, 4'h8, 1'b0); step("R6 over limit");
      acc(7'd6, 16'h0000, 4'h8, 1'b0); step("R6 bottom");

      // R7: system-only attribute
      wr(2, 7, mk_desc(1'b1, 8'hFF, 16'h0300)); la_stb = 1'b0; step("R5 idle");
      acc(7'd7, 16'h0010, 4'h9, 1'b0); step("R7 normal mode blocked");
      acc(7'd7, 16'h0010, 4'h9, 1'b1); step("R7 system mode ok");

      // R8: segment out of table
      acc(7'd64, 16'h0000, 4'h8, 1'b1); step("R8 seg 64");
      acc(7'd127, 16'h0000, 4'hC, 1'b1); step("R8 seg 127");

      // R5: non-memory status or no strobe
      acc(7'd5, 16'h0001, 4'h0, 1'b0); step("R5 non-memory status");
      acc(7'd5, 16'h0001, 4'hA, 1'b0); step("R5 non-memory status");
      la_stb = 1'b0; la_status = 4'h8; step("R5 no strobe");

      // R10: write and lookup of the same entry in one cycle
      wr(1, 9, mk_desc(1'b0, 8'hFF, 16'h0100)); la_stb = 1'b0; step("R5 idle");
      wr(1, 9, mk_desc(1'b0, 8'hFF, 16'h0200));
      acc(7'd9, 16'h0005, 4'h8, 1'b0); step("R10 old descriptor");
      acc(7'd9, 16'h0005, 4'h8, 1'b0); step("R10 new descriptor");

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         cfg_reg = 8'($urandom);
         if ($urandom_range(0, 7) != 0) cfg_reg[1] = 1'b1;
         bucket = 2'($urandom);
         case (bucket)
            2'd0: sc = 4'hC; 2'd1: sc = 4'h8; 2'd2: sc = 4'h9;
            default: sc = $urandom_range(0, 15);
         endcase
         la_stb = ($urandom_range(0, 4) != 0);
         la_status = 4'(sc);
         la_seg = ($urandom_range(0, 9) == 0) ? 7'($urandom) : {1'b0, 6'($urandom_range(0, 7))};
         la_off = 16'($urandom);
         la_sys = 1'($urandom);
         dw_en = 3'($urandom);
         for (int k = 0; k < 3; k++) begin
            dw_idx[k*6 +: 6] = ($urandom_range(0, 1) == 0) ? la_seg[5:0] : 6'($urandom_range(0, 7));
            dw_data[k*25 +: 25] = {1'($urandom_range(0, 3) == 0), 8'($urandom), 16'($urandom)};
         end
         step(e_viol ? "R11 random" : "R3 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule